// File: doc/BRIEF.md
# Dual-Clock Shift and Storage Register

This block is a serial-in register with two stages. A shift stage takes one bit per rising edge of its own clock. A storage stage takes a copy of the whole shift stage when its separate clock rises. The storage stage drives a row of sink-control bits. Each bit stands for an open-drain driver: a 1 turns the sink on and a 0 leaves the pin floating. An active-low output-enable forces every sink off without touching any stored value.

A cascade output carries the top bit of the shift stage, so several devices can be chained into one long register. It is retimed on the falling edge of the shift clock, which gives the next device half a period of hold margin. One active-low clear empties both stages and the cascade bit at once, with no clock needed. The shift and storage clocks may also be tied together. In that case the storage stage shows the contents the shift stage held before each edge.

Top module: `dual_clk_shift_store`

## Requirements
- R1: While `clr_n_i` is low, the shift stage, the storage stage and `cascade_o` are 0 at once, without any clock edge, so `sink_on_o` reads all zeros.
- R2: On each rising edge of `shclk_i`, the shift stage moves up by one bit: bit i takes bit i-1 and bit 0 takes `sdata_i`.
- R3: On each rising edge of `stclk_i`, the storage stage takes the whole shift stage. Edges of `shclk_i` alone never change the storage stage.
- R4: `cascade_o` equals the top bit (bit WIDTH-1) of the shift stage and changes only on the falling edge of `shclk_i`. Between a rising edge and the next falling edge it still shows the earlier top bit.
- R5: With `oe_n_i` low, `sink_on_o[i]` equals storage bit i. A value fed top bit first over WIDTH shift edges and then stored appears unchanged on `sink_on_o`.
- R6: With `oe_n_i` high, `sink_on_o` is all zeros. The storage stage keeps its value, and shifting, storing and `cascade_o` go on as normal.
- R7: When both clocks rise on the same edge, the storage stage takes the value the shift stage held before that edge.
- R8: When two devices are chained (`cascade_o` of the first drives `sdata_i` of the second, clocks shared), 16 shift edges followed by one store edge place the 16-bit word fed top bit first as {second, first}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sdata_i | input | 1 | Serial data in, taken at the rising edge of shclk_i |
| shclk_i | input | 1 | Shift clock |
| stclk_i | input | 1 | Storage clock |
| clr_n_i | input | 1 | Asynchronous clear of all registers, active low |
| oe_n_i | input | 1 | Output enable, active low |
| sink_on_o | output | WIDTH | Sink-control bits, 1 = sink on |
| cascade_o | output | 1 | Retimed serial output for chaining |

## Verification
The functions most likely to collide are the shift and the storage transfer. The bench makes both clocks rise at the same instant and shifts a known sequence through. After every tied edge it expects the storage stage to show the shift contents from one edge earlier. A second collision is between the output enable and the stored data. The bench changes the shift contents and stores them while the outputs are disabled. It expects zeros during that time, then the newly stored value once the outputs are enabled again.

// File: rtl/dcss_pkg.sv
package dcss_pkg;
    // State of the falling-edge retiming stage for the cascade bit
    typedef struct packed {
        logic cas;
        logic armed;
    } dcss_tail_t;
endpackage

// File: rtl/dcss_shift_stage.sv
module dcss_shift_stage #(
    parameter int unsigned WIDTH = 8
) (
    input  logic             shclk_i,
    input  logic             clr_n_i,
    input  logic             sdata_i,
    output logic [WIDTH-1:0] bits_o,
    output logic             cascade_o
);
    import dcss_pkg::*;
    localparam int unsigned MSB = WIDTH - 1;

    typedef struct packed {
        logic [WIDTH-1:0] bits;
        logic             din;
        logic             armed;
    } head_t;

    head_t      head_d, head_q;
    dcss_tail_t tail_d, tail_q;

    always_comb begin
        head_d.bits  = {head_q.bits[MSB-1:0], sdata_i};
        head_d.din   = sdata_i;
        head_d.armed = 1'b1;
        tail_d.cas   = head_q.bits[MSB];
        tail_d.armed = 1'b1;
    end

    always_ff @(posedge shclk_i or negedge clr_n_i) begin
        if (!clr_n_i) head_q <= '0;
        else          head_q <= head_d;
    end

    always_ff @(negedge shclk_i or negedge clr_n_i) begin
        if (!clr_n_i) tail_q <= '0;
        else          tail_q <= tail_d;
    end

    assign bits_o    = head_q.bits;
    assign cascade_o = tail_q.cas;

    // R2: bits move up by one, the serial bit lands at position 0
    p_shift_up_r2: assert property (@(posedge shclk_i) disable iff (!clr_n_i)
        head_q.armed |=> (head_q.bits[MSB:1] == $past(head_q.bits[MSB-1:0]))
                         && (head_q.bits[0] == $past(sdata_i)));

    // R4: at a rising edge the cascade still shows the current top bit
    p_cascade_top_r4: assert property (@(posedge shclk_i) disable iff (!clr_n_i)
        tail_q.armed |-> (cascade_o == head_q.bits[MSB]));
endmodule

// File: rtl/dcss_store_stage.sv
module dcss_store_stage #(
    parameter int unsigned WIDTH = 8
) (
    input  logic             stclk_i,
    input  logic             clr_n_i,
    input  logic [WIDTH-1:0] shift_i,
    output logic [WIDTH-1:0] store_o
);
    typedef struct packed {
        logic [WIDTH-1:0] bits;
        logic             armed;
    } store_t;

    store_t st_d, st_q;

    always_comb begin
        st_d.bits  = shift_i;
        st_d.armed = 1'b1;
    end

    always_ff @(posedge stclk_i or negedge clr_n_i) begin
        if (!clr_n_i) st_q <= '0;
        else          st_q <= st_d;
    end

    assign store_o = st_q.bits;

    // R3: each store edge captures the shift contents seen at that edge
    p_store_copy_r3: assert property (@(posedge stclk_i) disable iff (!clr_n_i)
        st_q.armed |-> (st_q.bits == $past(shift_i)));
endmodule

// File: rtl/dcss_sink_gate.sv
module dcss_sink_gate #(
    parameter int unsigned WIDTH = 8
) (
    input  logic             oe_n_i,
    input  logic [WIDTH-1:0] store_i,
    output logic [WIDTH-1:0] sink_on_o
);
    for (genvar g = 0; g < WIDTH; g++) begin : g_pin
        always_comb begin
            sink_on_o[g] = store_i[g] & ~oe_n_i;
        end
    end
endmodule

// File: rtl/dual_clk_shift_store.sv
module dual_clk_shift_store #(
    parameter int unsigned WIDTH = 8
) (
    input  logic             sdata_i,
    input  logic             shclk_i,
    input  logic             stclk_i,
    input  logic             clr_n_i,
    input  logic             oe_n_i,
    output logic [WIDTH-1:0] sink_on_o,
    output logic             cascade_o
);
    logic [WIDTH-1:0] shift_w;
    logic [WIDTH-1:0] store_w;

    dcss_shift_stage #(.WIDTH(WIDTH)) u_shift (
        .shclk_i  (shclk_i),
        .clr_n_i  (clr_n_i),
        .sdata_i  (sdata_i),
        .bits_o   (shift_w),
        .cascade_o(cascade_o)
    );

    dcss_store_stage #(.WIDTH(WIDTH)) u_store (
        .stclk_i(stclk_i),
        .clr_n_i(clr_n_i),
        .shift_i(shift_w),
        .store_o(store_w)
    );

    dcss_sink_gate #(.WIDTH(WIDTH)) u_gate (
        .oe_n_i   (oe_n_i),
        .store_i  (store_w),
        .sink_on_o(sink_on_o)
    );

    // R1: a store edge during clear finds every output already empty
    p_clear_holds_r1: assert property (@(posedge stclk_i)
        !clr_n_i |-> (sink_on_o == '0) && (cascade_o == 1'b0));

    // R6: disabled outputs stay off whatever is stored
    p_oe_blocks_r6: assert property (@(posedge shclk_i) disable iff (!clr_n_i)
        oe_n_i |-> (sink_on_o == '0));
endmodule

// File: tb/dual_clk_shift_store_bench.sv
module dual_clk_shift_store_bench;
    localparam int W = 8;

    logic clk = 1'b0;
    logic sdata = 1'b0, shclk = 1'b0, stclk = 1'b0, clr_n = 1'b0, oe_n = 1'b0;
    logic [W-1:0] sink_a, sink_b;
    logic cas_a, cas_b;
    int total = 0, bad = 0, cycles = 0;
    logic [15:0] model = '0;   // {device B shift, device A shift}

    always #2.5 clk = ~clk;

    dual_clk_shift_store #(.WIDTH(W)) u_dual_clk_shift_store (
        .sdata_i(sdata), .shclk_i(shclk), .stclk_i(stclk), .clr_n_i(clr_n),
        .oe_n_i(oe_n), .sink_on_o(sink_a), .cascade_o(cas_a));

    dual_clk_shift_store #(.WIDTH(W)) u_dual_clk_shift_store_nx (
        .sdata_i(cas_a), .shclk_i(shclk), .stclk_i(stclk), .clr_n_i(clr_n),
        .oe_n_i(oe_n), .sink_on_o(sink_b), .cascade_o(cas_b));

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // one shift pulse; probes the cascade bit inside the high phase (R4)
    task automatic shift_bit(input logic b, input logic probe);
        logic old_top;
        old_top = model[W-1];
        sdata = b; #1;
        shclk = 1'b1; #1.25;
        if (probe) chk("R4 cascade before fall", {31'd0, cas_a}, {31'd0, old_top});
        #1.25; shclk = 1'b0; #1.5;
        model = {model[14:0], b};
        if (probe) chk("R4 cascade after fall", {31'd0, cas_a}, {31'd0, model[W-1]});
    endtask

    task automatic store_pulse();
        #1; stclk = 1'b1; #2.5; stclk = 1'b0; #1.5;
    endtask

    task automatic tied_pulse(input logic b);
        sdata = b; #1;
        shclk = 1'b1; stclk = 1'b1; #2.5;
        shclk = 1'b0; stclk = 1'b0; #1.5;
        model = {model[14:0], b};
    endtask

    initial begin
        while (cycles < 120000) begin
            @(posedge clk);
            cycles++;
        end
        bad++; total++;
        $display("FAIL watchdog actual=%0d expected=<120000", cycles);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [W-1:0] prev;
        logic [W-1:0] held;
        // R1: clear state, store edge during clear changes nothing
        #3; store_pulse();
        chk("R1 reset sinks A", {24'd0, sink_a}, 32'd0);
        chk("R1 reset sinks B", {24'd0, sink_b}, 32'd0);
        chk("R1 reset cascade", {31'd0, cas_a}, 32'd0);
        clr_n = 1'b1; #2;

        // R2/R3/R5/R8: every byte value, shifted top bit first then stored
        prev = '0;
        for (int v = 0; v < 256; v++) begin
            for (int k = W - 1; k >= 0; k--) shift_bit(v[k], (v % 37) == 5);
            store_pulse();
            chk("R5 byte on sinks A", {24'd0, sink_a}, v);
            if (v > 0) chk("R8 previous byte in B", {24'd0, sink_b}, {24'd0, prev});
            prev = v[W-1:0];
        end

        // R3: shift edges alone leave the storage untouched
        for (int k = 0; k < 5; k++) shift_bit(k[0], 1'b1);
        chk("R3 storage held over shifts", {24'd0, sink_a}, 32'd255);

        // R6: outputs off, storage kept, shifting/storing continue
        for (int k = W - 1; k >= 0; k--) shift_bit(8'hA5 >> k, 1'b0);
        store_pulse();
        oe_n = 1'b1; #2;
        chk("R6 disabled sinks A", {24'd0, sink_a}, 32'd0);
        oe_n = 1'b0; #2;
        chk("R6 storage kept", {24'd0, sink_a}, 32'hA5);
        oe_n = 1'b1; #1;
        for (int k = W - 1; k >= 0; k--) shift_bit(8'h3C >> k, 1'b1);
        store_pulse();
        chk("R6 disabled after store", {24'd0, sink_a}, 32'd0);
        oe_n = 1'b0; #2;
        chk("R6 store while disabled", {24'd0, sink_a}, 32'h3C);

        // R7: tied clocks, storage lags shift by one edge
        for (int k = 0; k < 12; k++) begin
            held = model[W-1:0];
            tied_pulse(((k * 5) % 3) == 1);
            chk("R7 tied clocks lag", {24'd0, sink_a}, {24'd0, held});
        end

        // R8: 16-bit words across the chain
        for (int i = 0; i < 64; i++) begin
            logic [15:0] w;
            w = 16'(i * 40503) ^ 16'(i << 3);
            for (int k = 15; k >= 0; k--) shift_bit(w[k], 1'b0);
            store_pulse();
            chk("R8 chain word", {16'd0, sink_b, sink_a}, {16'd0, w});
        end

        // R1: clear mid-run with no clock, then store an empty shift stage
        for (int k = W - 1; k >= 0; k--) shift_bit(1'b1, 1'b0);
        store_pulse();
        chk("R1 preload", {24'd0, sink_a}, 32'hFF);
        clr_n = 1'b0; #2;
        chk("R1 async sinks", {24'd0, sink_a}, 32'd0);
        chk("R1 async cascade", {31'd0, cas_a}, 32'd0);
        clr_n = 1'b1; #2;
        model = '0;
        store_pulse();
        chk("R1 shift stage emptied", {24'd0, sink_a}, 32'd0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule